// File: doc/BRIEF.md
# Pin-Driven Receive Gain Loader

This block holds the 5-bit receive gain word and offers two ways to load it. The slow way is a write request from the serial control port, which arrives here as a one-cycle strobe with the new value. The fast way borrows the transmit data bus. While the gain-select pin is high and the sync line is low, the upper five bus bits carry a gain value. When that value and both control levels have stayed unchanged for a set number of clock edges, the block commits it.

The same bus also carries transmit samples. While gain-select is low, each bus word is registered and passed on to the transmit datapath with a valid flag. While gain-select is high, that flag is held low and the last sample is kept. Each time the gain register is written, by either path, the block raises a one-cycle update pulse. A committed value drives the gain output from the next cycle on, with no further delay.

Top module: `pin_gain_loader`

## Requirements
- R1: After reset, `gain_o` is 0, `gain_upd_o` is 0, `tx_valid_o` is 0 and `tx_data_o` is 0.
- R2: The pin gain field is `bus_i[5:1]`. Bit 0 has no effect on the committed value or on the stability count.
- R3: A rising edge is qualified when `gain_sel_i` is 1 and `sync_i` is 0. On the third consecutive qualified edge that sees the same field, `gain_o` takes that field and `gain_upd_o` is 1 for the cycle that follows.
- R4: An edge with `sync_i` high or `gain_sel_i` low ends the run and causes no pin write. A later write then needs three fresh qualified edges.
- R5: A change of the field on a qualified edge restarts the count at one. The new value is committed on the third edge from the change if it is held that long.
- R6: A run produces only one commit. Holding the qualified state longer gives no further update pulse.
- R7: `spi_wr_i` high on an edge loads `spi_gain_i` into `gain_o` and raises `gain_upd_o` in the following cycle, whatever the bus pins are doing.
- R8: When a serial write and a pin commit fall on the same edge, the serial value is stored.
- R9: An edge with `gain_sel_i` low registers `bus_i` onto `tx_data_o` and sets `tx_valid_o` to 1.
- R10: An edge with `gain_sel_i` high sets `tx_valid_o` to 0 and leaves `tx_data_o` unchanged.
- R11: `gain_o` changes only in a cycle in which `gain_upd_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus sampling clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_i | input | 6 | Shared transmit data / gain bus |
| sync_i | input | 1 | Word sync; must be low for a gain write |
| gain_sel_i | input | 1 | High: bus carries gain; low: bus carries transmit data |
| spi_wr_i | input | 1 | One-cycle write strobe from the serial control port |
| spi_gain_i | input | 5 | Gain value supplied with the serial strobe |
| tx_data_o | output | 6 | Registered transmit sample |
| tx_valid_o | output | 1 | Transmit sample valid |
| gain_o | output | 5 | Current receive gain |
| gain_upd_o | output | 1 | One-cycle pulse on every gain register write |

## Verification
The hardest cases to reach are runs that come very close to a commit and then fail. These include a run broken on its second edge, a field change exactly one edge before the commit, a toggle on bit 0 that must not break the run, and a serial strobe on the very edge a pin commit matures. Directed sequences build each of these edge by edge. A long random phase then follows, with gain-select biased high and the field changing only rarely. This mix makes windows of two, three and more edges common, and it lets serial strobes land inside live windows.

// File: rtl/pgl_pkg.sv
package pgl_pkg;
    // Which source writes the gain register in a given cycle
    typedef enum logic [1:0] {
        SRC_NONE   = 2'd0,
        SRC_PIN    = 2'd1,
        SRC_SERIAL = 2'd2
    } gain_src_e;
endpackage

// File: rtl/pgl_window.sv
module pgl_window #(
    parameter int BUS_W    = 6,
    parameter int GAIN_W   = 5,
    parameter int GAIN_LSB = 1,
    parameter int HOLD     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BUS_W-1:0]  bus_i,
    input  logic              sync_i,
    input  logic              sel_i,
    output logic              commit_o,
    output logic [GAIN_W-1:0] field_o
);
    localparam int CW = $clog2(HOLD + 1);
    localparam logic [CW-1:0] HOLD_C = CW'(HOLD);
    localparam logic [CW-1:0] ONE_C  = CW'(1);

    typedef struct packed {
        logic [CW-1:0]     cnt;
        logic [GAIN_W-1:0] held;
    } win_t;

    win_t st_d, st_q;
    logic qual;
    logic same;

    always_comb begin
        st_d     = st_q;
        field_o  = bus_i[GAIN_LSB +: GAIN_W];
        qual     = sel_i & ~sync_i;
        same     = (st_q.cnt != '0) && (field_o == st_q.held);
        commit_o = 1'b0;
        if (!qual) begin
            st_d.cnt = '0;
        end else begin
            st_d.held = field_o;
            if (!same) begin
                st_d.cnt = ONE_C;
            end else if (st_q.cnt != HOLD_C) begin
                st_d.cnt = st_q.cnt + ONE_C;
            end
            commit_o = (st_d.cnt == HOLD_C) && !(same && st_q.cnt == HOLD_C);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/pgl_gain_reg.sv
module pgl_gain_reg #(
    parameter int GAIN_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pin_commit_i,
    input  logic [GAIN_W-1:0] pin_field_i,
    input  logic              ser_wr_i,
    input  logic [GAIN_W-1:0] ser_gain_i,
    output logic [GAIN_W-1:0] gain_o,
    output logic              upd_o
);
    import pgl_pkg::*;

    typedef struct packed {
        logic [GAIN_W-1:0] gain;
        logic              upd;
    } greg_t;

    greg_t st_d, st_q;
    gain_src_e src;

    always_comb begin
        if (ser_wr_i)          src = SRC_SERIAL;
        else if (pin_commit_i) src = SRC_PIN;
        else                   src = SRC_NONE;

        st_d     = st_q;
        st_d.upd = (src != SRC_NONE);
        case (src)
            SRC_SERIAL: st_d.gain = ser_gain_i;
            SRC_PIN:    st_d.gain = pin_field_i;
            default:    st_d.gain = st_q.gain;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign gain_o = st_q.gain;
    assign upd_o  = st_q.upd;
endmodule

// File: rtl/pgl_tx_route.sv
module pgl_tx_route #(
    parameter int BUS_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BUS_W-1:0] bus_i,
    input  logic             sel_i,
    output logic [BUS_W-1:0] data_o,
    output logic             valid_o
);
    typedef struct packed {
        logic [BUS_W-1:0] data;
        logic             valid;
    } tx_t;

    tx_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.valid = ~sel_i;
        if (!sel_i) st_d.data = bus_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign data_o  = st_q.data;
    assign valid_o = st_q.valid;
endmodule

// File: rtl/pin_gain_loader.sv
module pin_gain_loader #(
    parameter int BUS_W    = 6,
    parameter int GAIN_W   = 5,
    parameter int GAIN_LSB = 1,
    parameter int HOLD     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BUS_W-1:0]  bus_i,
    input  logic              sync_i,
    input  logic              gain_sel_i,
    input  logic              spi_wr_i,
    input  logic [GAIN_W-1:0] spi_gain_i,
    output logic [BUS_W-1:0]  tx_data_o,
    output logic              tx_valid_o,
    output logic [GAIN_W-1:0] gain_o,
    output logic              gain_upd_o
);
    logic              pin_commit;
    logic [GAIN_W-1:0] pin_field;

    pgl_window #(
        .BUS_W(BUS_W), .GAIN_W(GAIN_W), .GAIN_LSB(GAIN_LSB), .HOLD(HOLD)
    ) u_window (
        .clk(clk), .rst_n(rst_n), .bus_i(bus_i), .sync_i(sync_i),
        .sel_i(gain_sel_i), .commit_o(pin_commit), .field_o(pin_field)
    );

    pgl_gain_reg #(.GAIN_W(GAIN_W)) u_greg (
        .clk(clk), .rst_n(rst_n), .pin_commit_i(pin_commit),
        .pin_field_i(pin_field), .ser_wr_i(spi_wr_i), .ser_gain_i(spi_gain_i),
        .gain_o(gain_o), .upd_o(gain_upd_o)
    );

    pgl_tx_route #(.BUS_W(BUS_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .bus_i(bus_i), .sel_i(gain_sel_i),
        .data_o(tx_data_o), .valid_o(tx_valid_o)
    );
endmodule

// File: rtl/pgl_checker.sv
module pgl_checker #(
    parameter int BUS_W    = 6,
    parameter int GAIN_W   = 5,
    parameter int GAIN_LSB = 1,
    parameter int HOLD     = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [BUS_W-1:0]  bus_i,
    input logic              sync_i,
    input logic              gain_sel_i,
    input logic              spi_wr_i,
    input logic [GAIN_W-1:0] spi_gain_i,
    input logic [BUS_W-1:0]  tx_data_o,
    input logic              tx_valid_o,
    input logic [GAIN_W-1:0] gain_o,
    input logic              gain_upd_o
);
    localparam int CW = $clog2(HOLD + 1);
    localparam logic [CW-1:0] HOLD_C = CW'(HOLD);

    // Independent run-length tracker for the stability window
    logic [CW-1:0]     run_q;
    logic [GAIN_W-1:0] last_q;
    logic [GAIN_W-1:0] fld;
    assign fld = bus_i[GAIN_LSB +: GAIN_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q  <= '0;
            last_q <= '0;
        end else if (!gain_sel_i || sync_i) begin
            run_q <= '0;
        end else begin
            last_q <= fld;
            if (run_q == '0 || fld != last_q) run_q <= CW'(1);
            else if (run_q != HOLD_C)         run_q <= run_q + CW'(1);
        end
    end

    // R3
    pin_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gain_upd_o && !$past(spi_wr_i)) |-> (run_q == HOLD_C && gain_o == $past(fld)));

    // R4
    no_pin_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((!gain_sel_i || sync_i) && !spi_wr_i) |=> !gain_upd_o);

    // R7
    serial_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_wr_i |=> (gain_upd_o && gain_o == $past(spi_gain_i)));

    // R9
    tx_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gain_sel_i |=> (tx_valid_o && tx_data_o == $past(bus_i)));

    // R10
    tx_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gain_sel_i |=> (!tx_valid_o && $stable(tx_data_o)));

    // R11
    gain_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gain_upd_o |-> $stable(gain_o));
endmodule

bind pin_gain_loader pgl_checker #(
    .BUS_W(BUS_W), .GAIN_W(GAIN_W), .GAIN_LSB(GAIN_LSB), .HOLD(HOLD)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_i(bus_i), .sync_i(sync_i),
    .gain_sel_i(gain_sel_i), .spi_wr_i(spi_wr_i), .spi_gain_i(spi_gain_i),
    .tx_data_o(tx_data_o), .tx_valid_o(tx_valid_o), .gain_o(gain_o),
    .gain_upd_o(gain_upd_o)
);

// File: tb/pin_gain_loader_tb.sv
`timescale 1ns/1ps
module pin_gain_loader_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] bus = '0;
    logic       sync = 1'b0;
    logic       sel = 1'b0;
    logic       spi_wr = 1'b0;
    logic [4:0] spi_gain = '0;
    logic [5:0] tx_data;
    logic       tx_valid;
    logic [4:0] gain;
    logic       upd;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // reference state
    int         mcnt = 0;
    logic [4:0] mheld = '0;
    logic [4:0] e_gain = '0;
    logic       e_upd = 1'b0;
    logic [5:0] e_data = '0;
    logic       e_valid = 1'b0;

    always #2 clk = ~clk;

    pin_gain_loader u_dut (
        .clk(clk), .rst_n(rst_n), .bus_i(bus), .sync_i(sync),
        .gain_sel_i(sel), .spi_wr_i(spi_wr), .spi_gain_i(spi_gain),
        .tx_data_o(tx_data), .tx_valid_o(tx_valid), .gain_o(gain),
        .gain_upd_o(upd)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic model_edge();
        logic [4:0] f;
        logic       q;
        int         nc;
        logic       pc;
        f = bus[5:1];
        q = sel & ~sync;
        if (!q)                          nc = 0;
        else if (mcnt > 0 && f == mheld) nc = (mcnt >= 3) ? 3 : mcnt + 1;
        else                             nc = 1;
        pc = q && (nc == 3) && !(mcnt == 3 && f == mheld);
        if (q) mheld = f;
        mcnt  = nc;
        e_upd = spi_wr | pc;
        if (spi_wr)  e_gain = spi_gain;
        else if (pc) e_gain = f;
        if (!sel) begin
            e_data  = bus;
            e_valid = 1'b1;
        end else begin
            e_valid = 1'b0;
        end
    endtask

    task automatic compare(input string req);
        chk(req, "gain_o", 32'(gain), 32'(e_gain));
        chk(req, "gain_upd_o", 32'(upd), 32'(e_upd));
        chk(req, "tx_valid_o", 32'(tx_valid), 32'(e_valid));
        chk(req, "tx_data_o", 32'(tx_data), 32'(e_data));
    endtask

    // inputs are set at a falling edge before calling
    task automatic step(input string req);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare(req);
        spi_wr = 1'b0;
    endtask

    task automatic put(input logic s, input logic y, input logic [4:0] f, input logic b0);
        sel  = s;
        sync = y;
        bus  = {f, b0};
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1d2c_3b4a));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1", "gain_o", 32'(gain), 0);
        chk("R1", "gain_upd_o", 32'(upd), 0);
        chk("R1", "tx_valid_o", 32'(tx_valid), 0);
        chk("R1", "tx_data_o", 32'(tx_data), 0);

        // R9: transmit pass-through with gain pin low
        put(0, 0, 5'h0b, 1); step("R9");
        put(0, 1, 5'h1f, 0); step("R9");
        put(0, 0, 5'h04, 1); step("R9");

        // R3: exactly three qualified edges commit; R10 blocks tx
        put(1, 0, 5'h15, 0); step("R3");
        step("R3");
        chk("R3", "no early commit", 32'(gain), 0);
        step("R3");
        chk("R3", "commit value", 32'(gain), 32'h15);
        chk("R3", "commit pulse", 32'(upd), 1);
        chk("R10", "tx held", 32'(tx_data), 32'h09);

        // R6: holding longer gives no more pulses; R2: bit0 toggles ignored
        for (int i = 0; i < 5; i++) begin
            bus[0] = ~bus[0];
            step("R6");
        end

        // R4: sync high breaks the run
        put(1, 0, 5'h0a, 0); step("R4");
        step("R4");
        put(1, 1, 5'h0a, 0); step("R4");
        put(1, 0, 5'h0a, 0); step("R4");
        step("R4");
        chk("R4", "restart no commit", 32'(gain), 32'h15);
        step("R4");
        chk("R4", "commit after restart", 32'(gain), 32'h0a);

        // R4: gain pin low breaks the run
        put(1, 0, 5'h03, 0); step("R4");
        step("R4");
        put(0, 0, 5'h03, 0); step("R4");
        put(1, 0, 5'h03, 0); step("R4");
        chk("R4", "no write after break", 32'(gain), 32'h0a);

        // R5: field change just before commit restarts
        put(1, 0, 5'h11, 0); step("R5");
        step("R5");
        put(1, 0, 5'h12, 0); step("R5");
        step("R5");
        chk("R5", "restart held", 32'(gain), 32'h0a);
        step("R5");
        chk("R5", "new value", 32'(gain), 32'h12);

        // R2: bit0 changing inside a window does not restart
        put(1, 0, 5'h07, 0); step("R2");
        bus[0] = 1'b1; step("R2");
        bus[0] = 1'b0; step("R2");
        chk("R2", "field from bits 5:1", 32'(gain), 32'h07);

        // R7: serial write with gain pin low
        put(0, 0, 5'h1c, 0); spi_wr = 1'b1; spi_gain = 5'h19; step("R7");
        chk("R7", "serial value", 32'(gain), 32'h19);
        step("R7");

        // R8: serial strobe on the edge a pin commit matures
        put(1, 0, 5'h02, 0); step("R8");
        step("R8");
        spi_wr = 1'b1; spi_gain = 5'h1e; step("R8");
        chk("R8", "serial wins", 32'(gain), 32'h1e);
        step("R8");
        chk("R8", "no late pin commit", 32'(gain), 32'h1e);

        // R11: random traffic
        put(0, 0, 5'h00, 0); step("R11");
        for (int i = 0; i < 4000; i++) begin
            sel = ($urandom % 8) != 0;
            sync = ($urandom % 10) == 0;
            if (($urandom % 6) == 0) bus[5:1] = 5'($urandom);
            bus[0] = 1'($urandom);
            spi_wr = ($urandom % 25) == 0;
            spi_gain = 5'($urandom);
            step("R11");
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule